// File: doc/BRIEF.md
# Lowest-Priority Interrupt Target Arbiter

This block takes one interrupt message and hands it to exactly one of N processors. Each message has an 8-bit vector and a logical destination mask. Every processor presents its current task priority and its logical ID. The block first forms a candidate set by ANDing the destination mask with each processor's logical ID. A candidate may take the interrupt only when its task-priority class is below the vector's class. Of the processors that qualify, the one with the numerically lowest task priority receives the interrupt. A rotating pointer breaks ties, so processors at the same priority take interrupts in turn.

The block holds one message at a time. If no candidate can accept it, the message stays inside the block and the input refuses new messages. The block evaluates the held message again on every clock, so a drop in any task priority releases it. Two kinds of message are dropped at the input and raise an error pulse: a message whose vector falls in the reserved range, and a message whose destination mask is all zeros.

Top module: `lowpri_arb`

## Requirements
- R1: After reset, `msg_ready` is 1 and `dlv_valid`, `dlv_onehot`, `err_vector` and `err_dest` are all 0. `msg_ready` is 0 whenever a message is held.
- R2: A message accepted with a vector below 0x20 is dropped. `err_vector` is 1 in the cycle after acceptance, no delivery follows, and `msg_ready` stays 1. A vector of 0x20 is accepted normally.
- R3: A message accepted with a destination mask of 0x00 is dropped. `err_dest` is 1 in the cycle after acceptance, no delivery follows, and `msg_ready` stays 1.
- R4: Processor i is a candidate only when (destination AND logical ID of i) is nonzero. Processor i's logical ID is at bits [8i+7:8i] of `cpu_lid`.
- R5: A candidate qualifies only when bits [7:4] of its task priority are strictly less than vector bits [7:4]. An equal class does not qualify. Processor i's task priority is at bits [8i+7:8i] of `cpu_tpr`.
- R6: Among the qualifying candidates, the one with the lowest full 8-bit task priority is chosen.
- R7: Ties at the lowest priority go to the first tied processor found when searching upward (with wraparound) from a pointer. The pointer is 0 after reset and becomes (winner+1) mod N after each delivery.
- R8: A delivery sets `dlv_valid` for exactly one cycle. In that cycle `dlv_onehot` has bit i set for winner i, and `dlv_vector` carries the message vector. `dlv_onehot` is 0 whenever `dlv_valid` is 0. The earliest delivery comes in the cycle after the one following acceptance.
- R9: When no candidate qualifies, the message is held and nothing is delivered. Once a task priority changes so that a candidate qualifies, delivery follows after the next clock edge.
- R10: While a message is held, new input messages are refused. The held vector and destination are the ones captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Offered message is present |
| msg_ready | output | 1 | Block can take a message |
| msg_vector | input | 8 | Interrupt vector of offered message |
| msg_dest | input | IDW | Logical destination mask |
| cpu_tpr | input | 8*N | Task priority per processor |
| cpu_lid | input | IDW*N | Logical ID per processor |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_onehot | output | N | Chosen processor, one-hot |
| dlv_vector | output | 8 | Vector being delivered |
| err_vector | output | 1 | Reserved-vector drop pulse |
| err_dest | output | 1 | Empty-destination drop pulse |

## Verification
The bench uses the default N=4 and IDW=8, with N a power of two. This small size lets a run of tie deliveries carry the rotating pointer past the top index and back to zero. One-bit logical IDs give single-target checks. Overlapping multi-bit IDs test the masking. With four priorities the bench can place a lower-priority processor outside the destination and a blocked processor at the vector's own class, next to processors that do qualify.

// File: rtl/lowpri_arb.sv
module lowpri_arb #(
  parameter int N   = 4,
  parameter int IDW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [7:0]       msg_vector,
  input  logic [IDW-1:0]   msg_dest,
  input  logic [N*8-1:0]   cpu_tpr,
  input  logic [N*IDW-1:0] cpu_lid,
  output logic             dlv_valid,
  output logic [N-1:0]     dlv_onehot,
  output logic [7:0]       dlv_vector,
  output logic             err_vector,
  output logic             err_dest
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [7:0] VEC_FLOOR = 8'h20;

  logic           pend;
  logic [7:0]     p_vec;
  logic [IDW-1:0] p_dest;
  logic [PW-1:0]  rr_ptr;
  logic [N-1:0]   cand, elig;
  logic [7:0]     min_tpr;
  logic           hit;
  logic [PW-1:0]  win;
  logic [PW-1:0]  nxt_ptr;

  wire accept  = msg_valid && msg_ready;
  wire vec_bad = msg_vector < VEC_FLOOR;
  wire dst_bad = (msg_dest == '0);

  assign msg_ready = !pend;

  for (genvar g = 0; g < N; g++) begin : g_cpu
    wire [7:0] tpr = cpu_tpr[8*g +: 8];
    assign cand[g] = |(cpu_lid[IDW*g +: IDW] & p_dest);
    assign elig[g] = pend && cand[g] && (tpr[7:4] < p_vec[7:4]);
  end

  always_comb begin
    min_tpr = 8'hFF;
    for (int i = 0; i < N; i++)
      if (elig[i] && cpu_tpr[8*i +: 8] < min_tpr) min_tpr = cpu_tpr[8*i +: 8];
  end

  always_comb begin
    int idx;
    hit = 1'b0;
    win = '0;
    idx = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(rr_ptr) + k) % N;
      if (!hit && elig[idx] && cpu_tpr[8*idx +: 8] == min_tpr) begin
        hit = 1'b1;
        win = PW'(idx);
      end
    end
  end

  assign nxt_ptr = PW'((int'(win) + 1) % N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      p_vec      <= '0;
      p_dest     <= '0;
      rr_ptr     <= '0;
      dlv_valid  <= 1'b0;
      dlv_onehot <= '0;
      dlv_vector <= '0;
      err_vector <= 1'b0;
      err_dest   <= 1'b0;
    end else begin
      dlv_valid  <= 1'b0;
      dlv_onehot <= '0;
      err_vector <= 1'b0;
      err_dest   <= 1'b0;
      if (pend && hit) begin
        pend       <= 1'b0;
        dlv_valid  <= 1'b1;
        dlv_onehot <= N'(1) << win;
        dlv_vector <= p_vec;
        rr_ptr     <= nxt_ptr;
      end
      if (accept) begin
        err_vector <= vec_bad;
        err_dest   <= dst_bad;
        if (!vec_bad && !dst_bad) begin
          pend   <= 1'b1;
          p_vec  <= msg_vector;
          p_dest <= msg_dest;
        end
      end
    end
  end
endmodule

// File: rtl/lowpri_arb_chk.sv
module lowpri_arb_chk #(
  parameter int N   = 4,
  parameter int IDW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_vector,
  input logic [IDW-1:0]   msg_dest,
  input logic [N*8-1:0]   cpu_tpr,
  input logic             dlv_valid,
  input logic [N-1:0]     dlv_onehot,
  input logic [7:0]       dlv_vector,
  input logic             err_vector,
  input logic             err_dest
);
  logic [N*8-1:0] prev_tpr;
  logic           win_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_tpr <= '0;
    else        prev_tpr <= cpu_tpr;

  always_comb begin
    win_ok = 1'b0;
    for (int i = 0; i < N; i++)
      if (dlv_onehot[i] && prev_tpr[8*i+4 +: 4] < dlv_vector[7:4]) win_ok = 1'b1;
  end

  wire take     = msg_valid && msg_ready;
  wire good_msg = (msg_vector >= 8'h20) && (msg_dest != '0);

  AST_ONE_WINNER:   assert property (@(posedge clk) disable iff (!rst_n) dlv_valid |-> $countones(dlv_onehot) == 1); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) dlv_valid |=> !dlv_valid);                  // R8
  AST_QUIET_GRANT:  assert property (@(posedge clk) disable iff (!rst_n) !dlv_valid |-> dlv_onehot == '0);           // R8
  AST_HOLD_READY:   assert property (@(posedge clk) disable iff (!rst_n) (take && good_msg) |=> !msg_ready);         // R1
  AST_BAD_VEC_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (take && msg_vector < 8'h20) |=> err_vector); // R2
  AST_BAD_VEC_DROP: assert property (@(posedge clk) disable iff (!rst_n) (take && msg_vector < 8'h20) |=> (msg_ready && !dlv_valid)); // R2
  AST_ZERO_DST:     assert property (@(posedge clk) disable iff (!rst_n) (take && msg_dest == '0) |=> (err_dest && msg_ready)); // R3
  AST_VEC_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) dlv_valid |-> dlv_vector >= 8'h20);         // R2
  AST_CLASS_BELOW:  assert property (@(posedge clk) disable iff (!rst_n) dlv_valid |-> win_ok);                     // R5
endmodule

bind lowpri_arb lowpri_arb_chk #(.N(N), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .cpu_tpr(cpu_tpr),
  .dlv_valid(dlv_valid), .dlv_onehot(dlv_onehot), .dlv_vector(dlv_vector),
  .err_vector(err_vector), .err_dest(err_dest)
);

// File: tb/lowpri_arb_tb.sv
module lowpri_arb_tb;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic msg_valid = 0;
  logic msg_ready;
  logic [7:0] msg_vector = 0, msg_dest = 0;
  logic [N*8-1:0] cpu_tpr, cpu_lid;
  logic dlv_valid, err_vector, err_dest;
  logic [N-1:0] dlv_onehot;
  logic [7:0] dlv_vector;
  logic [7:0] tpr [N];
  logic [7:0] lid [N];
  int n_chk = 0, n_bad = 0, exp_ptr = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) begin
      cpu_tpr[8*i +: 8] = tpr[i];
      cpu_lid[8*i +: 8] = lid[i];
    end

  lowpri_arb #(.N(N), .IDW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .cpu_tpr(cpu_tpr), .cpu_lid(cpu_lid),
    .dlv_valid(dlv_valid), .dlv_onehot(dlv_onehot), .dlv_vector(dlv_vector),
    .err_vector(err_vector), .err_dest(err_dest));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [7:0] v, input logic [7:0] d);
    int best = 256, w = -1;
    for (int i = 0; i < N; i++)
      if ((d & lid[i]) != 0 && tpr[i][7:4] < v[7:4] && tpr[i] < best) best = tpr[i];
    for (int k = 0; k < N; k++) begin
      int j = (exp_ptr + k) % N;
      if (w < 0 && (d & lid[j]) != 0 && tpr[j][7:4] < v[7:4] && tpr[j] == best) w = j;
    end
    return w;
  endfunction

  task automatic send(input logic [7:0] v, input logic [7:0] d);
    @(negedge clk);
    msg_vector = v; msg_dest = d; msg_valid = 1;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic deliver(input string req, input logic [7:0] v, input logic [7:0] d);
    int w;
    send(v, d);
    w = pick(v, d);
    @(negedge clk);
    check({req, " valid"}, dlv_valid, 1);
    check({req, " target"}, dlv_onehot, 32'(1) << w);
    check({req, " vector"}, dlv_vector, v);
    exp_ptr = (w + 1) % N;
  endtask

  task automatic t_reset;
    check("R1 ready", msg_ready, 1);
    check("R1 valid", dlv_valid, 0);
    check("R1 onehot", dlv_onehot, 0);
    check("R1 errs", {err_vector, err_dest}, 0);
  endtask

  task automatic t_single;
    for (int i = 0; i < N; i++) begin tpr[i] = 0; lid[i] = 8'(1 << i); end
    deliver("R4 single", 8'h50, 8'h04);
    @(negedge clk);
    check("R8 pulse end", dlv_valid, 0);
    check("R8 onehot idle", dlv_onehot, 0);
  endtask

  task automatic t_lowest;
    tpr[0] = 8'h08; tpr[1] = 8'h12; tpr[2] = 8'h05; tpr[3] = 8'h10;
    deliver("R6 lowest", 8'h40, 8'hFF);
    check("R6 p2", dlv_onehot, 4'b0100);
    tpr[2] = 8'h01;
    deliver("R6 outside dest", 8'h40, 8'h0B);
    check("R6 p0", dlv_onehot, 4'b0001);
  endtask

  task automatic t_masking;
    lid[0] = 8'h81; lid[1] = 8'h42; lid[2] = 8'h24; lid[3] = 8'h18;
    tpr[0] = 0; tpr[1] = 8'h07; tpr[2] = 0; tpr[3] = 0;
    deliver("R4 shared bit", 8'h60, 8'h40);
    check("R4 p1", dlv_onehot, 4'b0010);
    for (int i = 0; i < N; i++) lid[i] = 8'(1 << i);
  endtask

  task automatic t_blocked;
    tpr[0] = 8'h30; tpr[1] = 8'h00;
    send(8'h35, 8'h01);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R5 equal class blocked", dlv_valid, 0);
      check("R9 held ready", msg_ready, 0);
    end
    msg_vector = 8'h99; msg_dest = 8'hFF; msg_valid = 1;
    @(negedge clk);
    msg_valid = 0;
    check("R10 refused", dlv_valid, 0);
    tpr[0] = 8'h2F;
    @(negedge clk);
    check("R9 release", dlv_valid, 1);
    check("R9 target", dlv_onehot, 4'b0001);
    check("R10 kept vector", dlv_vector, 8'h35);
    exp_ptr = 1;
    @(negedge clk);
    check("R10 no second", dlv_valid, 0);
  endtask

  task automatic t_ties;
    for (int i = 0; i < N; i++) tpr[i] = 8'h03;
    for (int r = 0; r < 6; r++) deliver("R7 rotate", 8'h70, 8'h0F);
    deliver("R7 subset", 8'h70, 8'h05);
  endtask

  task automatic t_errors;
    send(8'h1F, 8'hFF);
    check("R2 flag", err_vector, 1);
    check("R2 ready", msg_ready, 1);
    @(negedge clk);
    check("R2 no delivery", dlv_valid, 0);
    check("R2 flag pulse", err_vector, 0);
    send(8'h44, 8'h00);
    check("R3 flag", err_dest, 1);
    check("R3 ready", msg_ready, 1);
    @(negedge clk);
    check("R3 no delivery", dlv_valid, 0);
    for (int i = 0; i < N; i++) tpr[i] = 0;
    deliver("R2 floor vector", 8'h20, 8'h08);
    check("R2 floor flag", err_vector, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin tpr[i] = 0; lid[i] = 8'(1 << i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_lowest();
    t_masking();
    t_blocked();
    t_ties();
    t_errors();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule